// File: doc/BRIEF.md
# SPI Serial Nonvolatile Memory Responder

This block is a synthesizable stand-in for a small serial nonvolatile memory on the slave side of an SPI mode 0 bus. After chip select falls, it takes the first byte as an opcode. It can return an identification triplet and stream stored data. It can set or clear a write-enable latch and take a page of write data. It can report a status byte, and it can enter or leave a deep power-down state. A byte array of `2**ADDR_W` entries serves as the storage.

The SPI pins are synchronised into the system clock. The block samples MOSI on a rising SCK and updates MISO on a falling SCK, most significant bit first.

An accepted page write raises a busy flag when chip select rises. The flag stays set for `BUSY_CYC` system clocks, and the write-enable latch drops when it clears. Software polls the status byte to see when the write has finished.

Top module: `nvspi_resp`

## Requirements
- R1: Opcode 0x9F returns three bytes: manufacturer `MFR_ID` (default 0xC2), type `TYPE_ID` (default 0x22), then a size code equal to `ADDR_W` (default 10, so 0x0A, capacity 2^10 bytes). Later bytes read 0x00.
- R2: Opcode 0x05 returns the status byte, repeating for as long as chip select is low. Bit 0 is busy, bit 1 is the write-enable latch, and bits 7..2 read 0. After reset the status byte is 0x00.
- R3: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it. Both are ignored while busy.
- R4: Opcode 0x03 is followed by a 24-bit address, sent most significant byte first. Data then streams out from that address while chip select stays low. The address is masked to `ADDR_W` bits, and the stream wraps from the last byte of the array to byte 0.
- R5: Opcode 0x0A, with the latch set and busy clear, is followed by a 24-bit address and up to 256 data bytes, which are stored. Data running past the end of the 256-byte page wraps to the start of the same page.
- R6: An accepted page write with at least one data byte sets busy when chip select rises. Busy stays set for `BUSY_CYC` clocks, and the write-enable latch clears at the same moment busy clears.
- R7: A page write issued while the latch is clear, or while busy, leaves memory and status unchanged.
- R8: Opcode 0xB9 enters deep power-down. In that state MISO is held at 0 and every opcode except 0xAB is ignored. Opcode 0xAB leaves power-down.
- R9: Mode 0 framing applies: MOSI is sampled on a rising SCK, MISO changes on a falling SCK, and bits go MSB first. Chip select high resets the bit and byte framing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | SPI chip select, active low |
| sck | input | 1 | SPI serial clock |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master |

## Verification
On every cycle, the assertions check the following. MISO stays low during power-down. Busy rises only on a chip-select release and always with the latch held. The latch is clear when busy falls. No storage write happens without the latch while idle. Framing returns to zero whenever chip select is high.

Only the bench scenarios can show the rest: the identification bytes, the address masking and the array-end wrap on reads, page wrap on long writes, and the discarding of writes without the latch. They also cover the ignored opcodes in power-down, which the bench compares against a byte model with known-location tracking.

// File: rtl/nvspi_resp.sv
module nvspi_resp #(
  parameter int ADDR_W = 10,
  parameter int BUSY_CYC = 300,
  parameter logic [7:0] MFR_ID = 8'hC2,
  parameter logic [7:0] TYPE_ID = 8'h22
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic mosi,
  output logic miso
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CW = $clog2(BUSY_CYC + 1);
  localparam logic [ADDR_W-1:0] PMASK = ADDR_W'(255);
  localparam logic [7:0] SIZE_CODE = 8'(ADDR_W);

  typedef enum logic [2:0] {ST_OPC, ST_ADR, ST_RD, ST_WR, ST_ID, ST_SR, ST_IGN} st_t;

  logic [2:0] cs_p, sck_p;
  logic [1:0] mosi_p;
  logic cs_s, cs_rise, sck_rise, sck_fall, mosi_s;
  assign cs_s = cs_p[1];
  assign cs_rise = cs_p[1] & ~cs_p[2];
  assign sck_rise = sck_p[1] & ~sck_p[2];
  assign sck_fall = ~sck_p[1] & sck_p[2];
  assign mosi_s = mosi_p[1];

  st_t st;
  logic [2:0] bitcnt;
  logic [6:0] shin;
  logic [7:0] tx, b;
  logic [1:0] idx;
  logic [ADDR_W-1:0] alr, ptr, a_new;
  logic is_wr, wr_ok, wr_hit, wel, busy, pd;
  logic [CW-1:0] bcnt;
  logic [7:0] mem [DEPTH];
  logic byte_done, mem_we;
  logic [7:0] status;

  assign b = {shin, mosi_s};
  assign byte_done = !cs_s && sck_rise && bitcnt == 3'd7;
  assign a_new = ADDR_W'({alr, b});
  assign status = {6'b0, wel, busy};
  assign mem_we = byte_done && st == ST_WR && wr_ok;
  assign miso = tx[7] & ~pd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_p <= 3'b111;
      sck_p <= 3'b000;
      mosi_p <= 2'b00;
    end else begin
      cs_p <= {cs_p[1:0], cs_n};
      sck_p <= {sck_p[1:0], sck};
      mosi_p <= {mosi_p[0], mosi};
    end
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem[ptr] <= b;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_OPC; bitcnt <= '0; shin <= '0; tx <= '0; idx <= '0;
      alr <= '0; ptr <= '0; is_wr <= 1'b0; wr_ok <= 1'b0; wr_hit <= 1'b0;
      wel <= 1'b0; busy <= 1'b0; pd <= 1'b0; bcnt <= '0;
    end else begin
      if (busy) begin
        bcnt <= bcnt - 1'b1;
        if (bcnt == CW'(1)) begin
          busy <= 1'b0;
          wel <= 1'b0;
        end
      end
      if (cs_s) begin
        st <= ST_OPC;
        bitcnt <= '0;
        tx <= '0;
        wr_hit <= 1'b0;
        if (cs_rise && wr_hit) begin
          busy <= 1'b1;
          bcnt <= CW'(BUSY_CYC);
        end
      end else if (sck_rise) begin
        shin <= b[6:0];
        bitcnt <= bitcnt + 1'b1;
        if (bitcnt == 3'd7) begin
          tx <= '0;
          unique case (st)
            ST_OPC: begin
              st <= ST_IGN;
              if (pd) begin
                if (b == 8'hAB) pd <= 1'b0;
              end else begin
                unique case (b)
                  8'h9F: begin tx <= MFR_ID; idx <= 2'd1; st <= ST_ID; end
                  8'h03: begin is_wr <= 1'b0; idx <= '0; st <= ST_ADR; end
                  8'h0A: begin is_wr <= 1'b1; wr_ok <= wel & ~busy; idx <= '0; st <= ST_ADR; end
                  8'h06: if (!busy) wel <= 1'b1;
                  8'h04: if (!busy) wel <= 1'b0;
                  8'h05: begin tx <= status; st <= ST_SR; end
                  8'hB9: pd <= 1'b1;
                  default: ;
                endcase
              end
            end
            ST_ADR: begin
              alr <= a_new;
              idx <= idx + 1'b1;
              if (idx == 2'd2) begin
                if (is_wr) begin
                  ptr <= a_new;
                  st <= ST_WR;
                end else begin
                  tx <= mem[a_new];
                  ptr <= a_new + 1'b1;
                  st <= ST_RD;
                end
              end
            end
            ST_RD: begin
              tx <= mem[ptr];
              ptr <= ptr + 1'b1;
            end
            ST_WR: begin
              if (wr_ok) wr_hit <= 1'b1;
              ptr <= (ptr & ~PMASK) | ((ptr + 1'b1) & PMASK);
            end
            ST_ID: begin
              tx <= idx == 2'd1 ? TYPE_ID : idx == 2'd2 ? SIZE_CODE : 8'h00;
              if (idx != 2'd3) idx <= idx + 1'b1;
            end
            ST_SR: tx <= status;
            default: ;
          endcase
        end
      end else if (sck_fall && bitcnt != 3'd0) begin
        tx <= {tx[6:0], 1'b0};
      end
    end
  end
endmodule

module nvspi_resp_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_s,
  input logic cs_rise,
  input logic busy,
  input logic wel,
  input logic pd,
  input logic miso,
  input logic mem_we,
  input logic [2:0] bitcnt
);
  // R8
  pd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) pd |-> !miso);
  // R6
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(cs_rise));
  // R6
  wel_drop_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> !wel);
  // R6
  busy_wel_chk: assert property (@(posedge clk) disable iff (!rst_n) busy |-> wel);
  // R7
  we_gate_chk: assert property (@(posedge clk) disable iff (!rst_n) mem_we |-> (wel && !busy));
  // R9
  frame_reset_chk: assert property (@(posedge clk) disable iff (!rst_n) cs_s |=> bitcnt == 3'd0);
endmodule

bind nvspi_resp nvspi_resp_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .cs_rise(cs_rise), .busy(busy),
  .wel(wel), .pd(pd), .miso(miso), .mem_we(mem_we), .bitcnt(bitcnt)
);

// File: tb/nvspi_resp_bench.sv
module nvspi_resp_bench;
  localparam int AW = 10;
  localparam int DEPTH = 1 << AW;
  localparam int BC = 300;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic miso;
  int total = 0, bad = 0;
  bit done = 0;

  logic [7:0] m_mem [DEPTH];
  bit known [DEPTH];
  bit m_wel = 0;

  always #4 clk = ~clk;

  nvspi_resp #(.ADDR_W(AW), .BUSY_CYC(BC)) u_nvspi_resp (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi), .miso(miso));

  function automatic logic [7:0] exp_sr(bit w, bit bsy);
    return {6'b0, w, bsy};
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic xb(input logic [7:0] t, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      mosi = t[i];
      repeat (4) @(negedge clk);
      r[i] = miso;
      sck = 1'b1;
      repeat (4) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic cs_lo();
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic cs_hi();
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] r;
    cs_lo(); xb(op, r); cs_hi();
  endtask

  task automatic rd_sr(output logic [7:0] s);
    logic [7:0] r;
    cs_lo(); xb(8'h05, r); xb(8'h00, s); cs_hi();
  endtask

  task automatic send_adr(input logic [23:0] a);
    logic [7:0] r;
    xb(a[23:16], r); xb(a[15:8], r); xb(a[7:0], r);
  endtask

  task automatic page_wr(input logic [23:0] a, input int n, input bit accept);
    logic [7:0] r, d;
    int base, off;
    base = int'(a[AW-1:0]) & ~255;
    off = int'(a[7:0]);
    cs_lo(); xb(8'h0A, r); send_adr(a);
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      xb(d, r);
      if (accept) begin
        m_mem[base + ((off + i) & 255)] = d;
        known[base + ((off + i) & 255)] = 1;
      end
    end
    cs_hi();
  endtask

  task automatic rd_chk(input logic [23:0] a, input int n, input string tag);
    logic [7:0] r;
    int p;
    p = int'(a[AW-1:0]);
    cs_lo(); xb(8'h03, r); send_adr(a);
    for (int i = 0; i < n; i++) begin
      xb(8'h00, r);
      if (known[p]) chk(r == m_mem[p], tag, r, m_mem[p]);
      p = (p + 1) % DEPTH;
    end
    cs_hi();
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    s = 8'h01;
    for (int k = 0; k < 40 && s[0]; k++) begin
      repeat (20) @(negedge clk);
      rd_sr(s);
    end
    chk(s == 8'h00, "R6 busy and latch cleared after write", s, 0);
    m_wel = 0;
  endtask

  task automatic do_write(input logic [23:0] a, input int n);
    logic [7:0] s;
    cmd1(8'h06); m_wel = 1;
    page_wr(a, n, 1'b1);
    rd_sr(s);
    chk(s == exp_sr(1, 1), "R6 busy set after page write", s, exp_sr(1, 1));
    page_wr(a ^ 24'h000040, 4, 1'b0);
    wait_idle();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] s, r;
    void'($urandom(32'd7));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    rd_sr(s);
    chk(s == 8'h00, "R2 reset status", s, 0);
    chk(miso == 1'b0, "R9 miso idle", miso, 0);

    cs_lo(); xb(8'h9F, r);
    xb(8'h00, r); chk(r == 8'hC2, "R1 manufacturer", r, 8'hC2);
    xb(8'h00, r); chk(r == 8'h22, "R1 type", r, 8'h22);
    xb(8'h00, r); chk(r == 8'h0A, "R1 size code", r, 8'h0A);
    xb(8'h00, r); chk(r == 8'h00, "R1 trailing zero", r, 0);
    cs_hi();

    cmd1(8'h06);
    cs_lo(); xb(8'h05, r);
    for (int i = 0; i < 3; i++) begin
      xb(8'h00, r); chk(r == 8'h02, "R2 R3 latch set, repeated status", r, 2);
    end
    cs_hi();
    cmd1(8'h04);
    rd_sr(s); chk(s == 8'h00, "R3 latch cleared", s, 0);

    page_wr(24'h000100, 8, 1'b0);
    rd_sr(s); chk(s == 8'h00, "R7 discarded write leaves status", s, 0);

    do_write(24'h0003F0, 32);
    do_write(24'h000000, 16);
    rd_chk(24'h000300, 16, "R5 page wrap on write");
    rd_chk(24'h0003FC, 8, "R4 read wraps at array end");
    rd_chk(24'h5AC001, 4, "R4 address masked");

    do_write(24'h000180, 300);
    rd_chk(24'h000100, 256, "R5 long write overwrites within page");

    for (int it = 0; it < 4; it++) begin
      logic [23:0] a;
      a = 24'($urandom);
      do_write(a, 1 + int'($urandom_range(63)));
      rd_chk(a, 1 + int'($urandom_range(39)), "R4 R5 random write then read");
    end

    cmd1(8'h06);
    cmd1(8'hB9);
    cs_lo(); xb(8'h05, r); xb(8'h00, r); chk(r == 8'h00, "R8 miso low in power-down", r, 0); cs_hi();
    cs_lo(); xb(8'h9F, r); xb(8'h00, r); chk(r == 8'h00, "R8 id ignored in power-down", r, 0); cs_hi();
    cmd1(8'h04);
    cmd1(8'hAB);
    rd_sr(s); chk(s == 8'h02, "R8 disable ignored in power-down, release works", s, 2);
    cmd1(8'h04);

    cs_lo(); xb(8'h9F, r); mosi = 1'b1; sck = 1'b1; repeat (4) @(negedge clk); sck = 1'b0;
    cs_hi();
    rd_sr(s); chk(s == 8'h00, "R9 partial frame discarded by chip select", s, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule